// File: doc/BRIEF.md
# Ping-Pong Bit Buffer for a Block Interleaver

This block is the storage half of a block interleaver serving one spatial stream. A single dual-port bit memory is split into two equal banks. During one block, incoming coded bits are stored into one bank at permuted addresses supplied from outside. At the same time the other bank, filled during the previous block, is drained in plain ascending address order. When a block ends, the two banks exchange roles. Reading in order a bank that was written in permuted order is what produces the interleaved bit stream.

Each cycle with the step strobe high moves one bit in and one bit out. The block length follows from a bandwidth flag and a two-bit modulation code. An internal read counter wraps at that length, and the bank select flips on the same strobe. The upper bank is reached by adding a fixed bias of 648 to the local address, so the largest block exactly fills one bank. Generating the permuted write addresses is the job of a neighbouring block.

Top module: `ilv_bank_buffer`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `bank_sel` is 0 and `rd_valid` is 0.
- R2: The block length N is the base times Nb. The base is 52 when `wide_bw`=0 and 108 when `wide_bw`=1. Nb is 1, 2, 4 or 6 for `mod_code` 00, 01, 10 or 11. `bank_sel` inverts after exactly N step strobes.
- R3: Each strobe stores `wr_bit` at local address `wr_addr`. When `bank_sel`=0 the bit goes to the lower bank, physical address `wr_addr`. When `bank_sel`=1 it goes to the upper bank, physical address `wr_addr`+648. Reads always use the bank that is not being written.
- R4: The k-th strobe of a block (k from 0) reads local address k of the bank filled during the previous block. The bit appears on `rd_bit` in the cycle after that strobe.
- R5: `rd_valid` is high in the cycle after a strobe only if at least one full block has been written since reset. It is low after strobes of the first block and after cycles with no strobe. `rd_bit` reads 0 whenever `rd_valid` is low.
- R6: A cycle with `step`=0 stores nothing. It leaves the read position and `bank_sel` unchanged.
- R7: The read-counter wrap and the bank swap happen on the same strobe. `bank_sel` does not change on any other strobe.
- R8: With the mode inputs held steady outside reset, the read counter always stays below N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One bit moves in and one bit moves out this cycle |
| wr_addr | input | 10 | Permuted local write address within the current bank |
| wr_bit | input | 1 | Coded bit to store |
| wide_bw | input | 1 | 0 selects the narrow channel (base 52), 1 selects the wide channel (base 108) |
| mod_code | input | 2 | Bits per subcarrier code: 00=1, 01=2, 10=4, 11=6 |
| rd_bit | output | 1 | Interleaved output bit |
| rd_valid | output | 1 | `rd_bit` carries a real bit |
| bank_sel | output | 1 | Bank being written: 0 lower, 1 upper |

## Verification
On every cycle, the assertions hold several properties: the read counter stays below the block length; idle cycles freeze the counter and the bank select; the wrap coincides with a bank swap and no other strobe flips the bank; valid output only ever follows a strobe; and both physical addresses stay inside the memory. Only the bench scenarios can show that the bits come back in the right order from the right bank. To do this, the bench writes a stride permutation in every one of the eight modes and compares each bit read in the next block with a value computed from its address. It also writes conflicting data during idle cycles to prove that nothing is stored then.

// File: rtl/ilv_bank_pkg.sv
package ilv_bank_pkg;

    localparam int CNT_W     = 10;
    localparam int BANK_SPAN = 648;

    typedef enum logic [1:0] {
        MOD_NB1 = 2'b00,
        MOD_NB2 = 2'b01,
        MOD_NB4 = 2'b10,
        MOD_NB6 = 2'b11
    } mod_e;

    typedef struct packed {
        logic wide;
        mod_e mod;
    } mode_t;

    function automatic int bits_per_carrier(mod_e m);
        case (m)
            MOD_NB1: return 1;
            MOD_NB2: return 2;
            MOD_NB4: return 4;
            default: return 6;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] block_len(mode_t md);
        int base;
        base = md.wide ? 108 : 52;
        return CNT_W'(base * bits_per_carrier(md.mod));
    endfunction

endpackage

// File: rtl/ilv_len_sel.sv
module ilv_len_sel
    import ilv_bank_pkg::*;
(
    input  mode_t            mode,
    output logic [CNT_W-1:0] len
);
    always_comb len = block_len(mode);
endmodule

// File: rtl/ilv_read_seq.sv
module ilv_read_seq
    import ilv_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             bank,
    output logic             primed
);
    logic at_end;
    always_comb at_end = (cnt >= len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            bank   <= 1'b0;
            primed <= 1'b0;
        end else if (step) begin
            if (at_end) begin
                cnt    <= '0;
                bank   <= ~bank;
                primed <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    p_cnt_below_len_r8: assert property (@(posedge clk) disable iff (rst)
        cnt < len);
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt) && $stable(bank));
    p_wrap_swaps_r7: assert property (@(posedge clk) disable iff (rst)
        (step && cnt == len - CNT_W'(1)) |=> (cnt == '0) && (bank != $past(bank)));
    p_no_mid_swap_r7: assert property (@(posedge clk) disable iff (rst)
        (step && cnt != len - CNT_W'(1)) |=> $stable(bank));
endmodule

// File: rtl/ilv_bit_ram.sv
module ilv_bit_ram #(
    parameter int DEPTH  = 1296,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);
    logic mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wbit;
        if (re) rbit <= mem[raddr];
    end

    p_addr_in_range_r3: assert property (@(posedge clk)
        (we |-> int'(waddr) < DEPTH) and (re |-> int'(raddr) < DEPTH));
endmodule

// File: rtl/ilv_bank_buffer.sv
module ilv_bank_buffer
    import ilv_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic [9:0] wr_addr,
    input  logic       wr_bit,
    input  logic       wide_bw,
    input  logic [1:0] mod_code,
    output logic       rd_bit,
    output logic       rd_valid,
    output logic       bank_sel
);
    localparam int DEPTH  = 2 * BANK_SPAN;
    localparam int ADDR_W = $clog2(DEPTH);

    mode_t            mode;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] rd_cnt;
    logic             primed;
    logic             ram_bit;
    logic             valid_q;
    logic [ADDR_W-1:0] wr_phys;
    logic [ADDR_W-1:0] rd_phys;

    always_comb begin
        mode.wide = wide_bw;
        mode.mod  = mod_e'(mod_code);
    end

    ilv_len_sel u_len (.mode(mode), .len(len));

    ilv_read_seq u_seq (
        .clk(clk), .rst(rst), .step(step), .len(len),
        .cnt(rd_cnt), .bank(bank_sel), .primed(primed)
    );

    always_comb begin
        wr_phys = ADDR_W'(wr_addr) + (bank_sel ? ADDR_W'(BANK_SPAN) : '0);
        rd_phys = ADDR_W'(rd_cnt)  + (bank_sel ? '0 : ADDR_W'(BANK_SPAN));
    end

    ilv_bit_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(step), .waddr(wr_phys), .wbit(wr_bit),
        .re(step), .raddr(rd_phys), .rbit(ram_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= step & primed;
    end

    always_comb begin
        rd_valid = valid_q;
        rd_bit   = ram_bit & valid_q;
    end

    p_valid_after_step_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(step));
    p_bit_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> !rd_bit);
endmodule

// File: tb/ilv_bank_buffer_bench.sv
module ilv_bank_buffer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic [9:0] wr_addr = '0;
    logic       wr_bit = 1'b0;
    logic       wide_bw = 1'b0;
    logic [1:0] mod_code = 2'b00;
    logic       rd_bit, rd_valid, bank_sel;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    ilv_bank_buffer u_ilv_bank_buffer (
        .clk(clk), .rst(rst), .step(step), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .wide_bw(wide_bw), .mod_code(mod_code),
        .rd_bit(rd_bit), .rd_valid(rd_valid), .bank_sel(bank_sel)
    );

    task automatic check(string req, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(bit w, int mc);
        int nb;
        case (mc)
            0: nb = 1;
            1: nb = 2;
            2: nb = 4;
            default: nb = 6;
        endcase
        return (w ? 108 : 52) * nb;
    endfunction

    function automatic bit pat(int a, int blk);
        return bit'((((a * 13) >> 2) ^ a ^ (blk * 5)) & 1);
    endfunction

    // called at a negedge; returns at the following negedge
    task automatic one_cycle(bit s, int a, bit d);
        step    = s;
        wr_addr = 10'(a);
        wr_bit  = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_mode(bit w, int mc);
        int n;
        n = exp_len(w, mc);
        rst = 1'b1; wide_bw = w; mod_code = 2'(mc); step = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1", int'(bank_sel), 0, "bank_sel in reset");
        check("R1", int'(rd_valid), 0, "rd_valid in reset");
        rst = 1'b0;
        one_cycle(1'b0, 0, 1'b0);
        check("R1", int'(bank_sel), 0, "bank_sel after reset");
        for (int blk = 0; blk < 3; blk++) begin
            int bad_bits;
            int bad_valid;
            bad_bits  = 0;
            bad_valid = 0;
            for (int k = 0; k < n; k++) begin
                int a;
                a = (k * 5 + blk) % n;
                one_cycle(1'b1, a, pat(a, blk));
                if (blk == 0) begin
                    if (rd_valid !== 1'b0) bad_valid++;
                end else begin
                    if (rd_valid !== 1'b1) bad_valid++;
                    if (rd_bit !== pat(k, blk - 1)) begin
                        bad_bits++;
                        if (bad_bits == 1)
                            check("R4", int'(rd_bit), int'(pat(k, blk - 1)), "ordered read bit");
                    end
                end
                if (k == n / 2)
                    check("R7", int'(bank_sel), blk % 2, "bank held mid-block");
                if (k == n / 3 && blk == 1) begin
                    // idle cycles: write a conflicting bit that must not land (R6)
                    one_cycle(1'b0, a, ~pat(a, blk));
                    check("R5", int'(rd_valid), 0, "rd_valid after idle cycle");
                    check("R6", int'(bank_sel), 1, "bank held over idle");
                    one_cycle(1'b0, a, ~pat(a, blk));
                end
                if (k < n - 1 && bank_sel !== 1'(blk % 2)) bad_valid++;
            end
            check("R4", bad_bits, 0, "mismatched read bits in block");
            check("R5", bad_valid, 0, "valid or bank errors in block");
            check("R2", int'(bank_sel), (blk + 1) % 2, "bank swap after N strobes");
        end
    endtask

    initial begin
        @(negedge clk);
        for (int w = 0; w < 2; w++)
            for (int mc = 0; mc < 4; mc++)
                run_mode(bit'(w), mc);
        rst = 1'b1;
        @(negedge clk);
        check("R1", int'(rd_valid), 0, "rd_valid on final reset");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule